// File: doc/BRIEF.md
# Register-List Multiple-Transfer Sequencer

This block carries out a move-multiple-registers operation. It takes a 16-bit register-list mask and issues one bus transfer for each selected register, moving data between the register file and memory. The caller supplies a ready-made base address, the transfer direction, the operand size and the addressing-mode fields. For each transfer the block reports the register index, the bus address and the write strobe. When the operation ends it gives the final address, which the caller writes back to the base register in postincrement and predecrement modes.

Before any bus activity starts, the block checks that the addressing mode is legal for the chosen direction. Transfers run from the lowest set mask bit upward. Each bus transfer is a request that stays asserted until an acknowledge arrives. A load ends with one extra read whose data is thrown away. In predecrement mode the mask maps to the registers in reverse order and the address counts downward.

Top module: `movem_seq`

## Requirements
- R1: Outside predecrement mode, mask bit i selects register index i on `reg_idx`. Indices 0 to 7 are the data registers D0 to D7, and 8 to 15 are the address registers A0 to A7.
- R2: In predecrement mode (`ea_mode` = 3'b100), mask bit i selects register index 15 − i. So bit 0 selects A7 (index 15) and bit 15 selects D0 (index 0).
- R3: There is exactly one transfer for each set mask bit, taken from the lowest set bit to the highest. `bus_req`, `bus_addr` and `reg_idx` hold steady until the cycle in which `bus_ack` is high.
- R4: The address step is 2 when `long_sz` = 0 and 4 when `long_sz` = 1. Outside predecrement mode, the n-th transfer (n counted from 0) uses `base_addr` + n·step. In predecrement mode it uses `base_addr` − (n+1)·step. `bus_we` is 1 for register-to-memory transfers (`to_mem` = 1).
- R5: A load (`to_mem` = 0) ends with one more read at the last transfer address plus one step. `rf_we` stays low for that read.
- R6: For loads, the legal modes are 010, 011, 101 and 110, plus 111 with `ea_reg` 000 to 011. Every other mode is illegal, including 000, 001, 100 and 111/100.
- R7: For stores, the legal modes are 010, 100, 101 and 110, plus 111 with `ea_reg` 000 or 001. Every other mode is illegal, including 011 and 111/010.
- R8: An illegal request makes `illegal` and `done` pulse together in the cycle after `start`. No bus request is issued and `base_we` stays low.
- R9: When `done` pulses, `final_addr` is the address one step past the last transfer in postincrement mode, or the last transfer address in predecrement mode. The dummy read does not count. `base_we` pulses with `done` only in modes 011 and 100.
- R10: A word load drives `rf_wdata` with bits 15:0 of `bus_rdata` sign-extended to 32 bits. A long load drives `bus_rdata` unchanged. `rf_we` and `rf_wdata` are valid in the cycle in which `bus_ack` is high.
- R11: A legal request with an all-zero mask pulses `done` in the cycle after `start`, with no bus request and `final_addr` equal to `base_addr`.
- R12: After reset all strobes are low. `done` is a single-cycle pulse in the cycle after the final acknowledge, and `bus_req` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| list_mask | input | 16 | Register-list mask |
| base_addr | input | 32 | Starting effective address |
| to_mem | input | 1 | 1: registers to memory, 0: memory to registers |
| long_sz | input | 1 | 1: 32-bit operands, 0: 16-bit operands |
| ea_mode | input | 3 | Addressing-mode field |
| ea_reg | input | 3 | Addressing-register field |
| bus_ack | input | 1 | Acknowledge that completes the current bus transfer |
| bus_rdata | input | 32 | Read data from memory |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | 32 | Transfer address |
| reg_idx | output | 4 | Register for the current transfer |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | Operation finished (pulse) |
| illegal | output | 1 | Addressing mode rejected (pulse) |
| final_addr | output | 32 | Value to write back to the base register |
| base_we | output | 1 | Write-back of `final_addr` required (pulse) |

## Verification
The first request is visible in the cycle after `start`, so the bench samples it at the next falling edge. `rf_we` and `rf_wdata` are combinational on `bus_ack`, so the bench checks them at the falling edge where it raises the acknowledge. Every acknowledge takes effect at the following rising edge. The bench therefore looks for the next request, or for `done` with `final_addr` and `base_we`, at the falling edge after that. For illegal requests and empty masks, the bench samples the status pulse one cycle after `start` and confirms one cycle later that the pulse has cleared. While the acknowledge is held back for zero to two cycles, the bench rechecks the address and register index at each falling edge to show they are held.

// File: rtl/movem_pkg.sv
package movem_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_XFER  = 2'd1,
      ST_DUMMY = 2'd2
   } seq_state_e;

   localparam logic [2:0] EA_DREG    = 3'b000;
   localparam logic [2:0] EA_AREG    = 3'b001;
   localparam logic [2:0] EA_IND     = 3'b010;
   localparam logic [2:0] EA_POSTINC = 3'b011;
   localparam logic [2:0] EA_PREDEC  = 3'b100;
   localparam logic [2:0] EA_DISP    = 3'b101;
   localparam logic [2:0] EA_INDEX   = 3'b110;
   localparam logic [2:0] EA_EXT     = 3'b111;
endpackage

// File: rtl/movem_mode_check.sv
module movem_mode_check
   import movem_pkg::*;
(
   input  logic [2:0] mode,
   input  logic [2:0] regf,
   input  logic       to_mem,
   output logic       legal
);
   logic load_ok, store_ok;

   always_comb begin
      case (mode)
         EA_IND, EA_POSTINC, EA_DISP, EA_INDEX: load_ok = 1'b1;
         EA_EXT:  load_ok = (regf[2] == 1'b0);
         default: load_ok = 1'b0;
      endcase
      case (mode)
         EA_IND, EA_PREDEC, EA_DISP, EA_INDEX: store_ok = 1'b1;
         EA_EXT:  store_ok = (regf[2:1] == 2'b00);
         default: store_ok = 1'b0;
      endcase
      legal = to_mem ? store_ok : load_ok;
   end
endmodule

// File: rtl/movem_prienc.sv
module movem_prienc #(
   parameter int W     = 16,
   localparam int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/movem_sext.sv
module movem_sext #(
   parameter int DATA_W    = 32,
   parameter int WORD_W    = 16,
   parameter bit SIGN_WORD = 1'b1
) (
   input  logic              long_sz,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] word_ext;

   generate
      if (SIGN_WORD) begin : g_sign
         assign word_ext = {{(DATA_W-WORD_W){din[WORD_W-1]}}, din[WORD_W-1:0]};
      end else begin : g_zero
         assign word_ext = {{(DATA_W-WORD_W){1'b0}}, din[WORD_W-1:0]};
      end
   endgenerate

   assign dout = long_sz ? din : word_ext;
endmodule

// File: rtl/movem_seq.sv
module movem_seq
   import movem_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int MASK_W     = 16,
   parameter int WORD_BYTES = 2,
   parameter int LONG_BYTES = 4,
   parameter bit SIGN_WORD  = 1'b1,
   localparam int IDX_W     = $clog2(MASK_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MASK_W-1:0] list_mask,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              to_mem,
   input  logic              long_sz,
   input  logic [2:0]        ea_mode,
   input  logic [2:0]        ea_reg,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              rf_we,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              done,
   output logic              illegal,
   output logic [ADDR_W-1:0] final_addr,
   output logic              base_we
);
   localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP_L = ADDR_W'(LONG_BYTES);
   localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(MASK_W - 1);

   generate
      if (MASK_W != (1 << IDX_W)) begin : g_bad_mask
         $error("movem_seq: MASK_W must be a power of two");
      end
      if (DATA_W < 16 || DATA_W < 8 * LONG_BYTES) begin : g_bad_data
         $error("movem_seq: DATA_W too narrow for the long operand");
      end
      if (LONG_BYTES <= WORD_BYTES) begin : g_bad_step
         $error("movem_seq: LONG_BYTES must exceed WORD_BYTES");
      end
   endgenerate

   seq_state_e        state_q;
   logic [MASK_W-1:0] rem_q;
   logic [ADDR_W-1:0] cur_q, final_q;
   logic              load_q, long_q, predec_q, wb_q;
   logic              done_q, illegal_q, base_we_q;

   logic              mode_legal;
   logic [IDX_W-1:0]  low_idx;
   logic              rem_any;
   logic [MASK_W-1:0] rem_next;
   logic [ADDR_W-1:0] step, start_step, next_addr;
   logic              start_predec, start_wb;

   movem_mode_check u_mode (
      .mode   (ea_mode),
      .regf   (ea_reg),
      .to_mem (to_mem),
      .legal  (mode_legal)
   );

   movem_prienc #(.W(MASK_W)) u_prienc (
      .vec (rem_q),
      .idx (low_idx),
      .any (rem_any)
   );

   movem_sext #(.DATA_W(DATA_W), .WORD_W(16), .SIGN_WORD(SIGN_WORD)) u_sext (
      .long_sz (long_q),
      .din     (bus_rdata),
      .dout    (rf_wdata)
   );

   assign step         = long_q ? STEP_L : STEP_W;
   assign start_step   = long_sz ? STEP_L : STEP_W;
   assign next_addr    = predec_q ? (cur_q - step) : (cur_q + step);
   assign rem_next     = rem_q & (rem_q - MASK_W'(1));
   assign start_predec = (ea_mode == EA_PREDEC);
   assign start_wb     = (ea_mode == EA_PREDEC) || (ea_mode == EA_POSTINC);

   assign bus_req    = (state_q == ST_XFER && rem_any) || (state_q == ST_DUMMY);
   assign bus_we     = (state_q == ST_XFER) && !load_q;
   assign bus_addr   = cur_q;
   assign reg_idx    = predec_q ? (TOP_IDX - low_idx) : low_idx;
   assign rf_we      = (state_q == ST_XFER) && load_q && bus_ack;
   assign done       = done_q;
   assign illegal    = illegal_q;
   assign final_addr = final_q;
   assign base_we    = base_we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rem_q     <= '0;
         cur_q     <= '0;
         final_q   <= '0;
         load_q    <= 1'b0;
         long_q    <= 1'b0;
         predec_q  <= 1'b0;
         wb_q      <= 1'b0;
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         base_we_q <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         base_we_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  load_q   <= !to_mem;
                  long_q   <= long_sz;
                  predec_q <= start_predec;
                  wb_q     <= start_wb;
                  rem_q    <= list_mask;
                  final_q  <= base_addr;
                  cur_q    <= start_predec ? (base_addr - start_step) : base_addr;
                  if (!mode_legal) begin
                     done_q    <= 1'b1;
                     illegal_q <= 1'b1;
                  end else if (list_mask == '0) begin
                     done_q    <= 1'b1;
                     base_we_q <= start_wb;
                  end else begin
                     state_q <= ST_XFER;
                  end
               end
            end
            ST_XFER: begin
               if (bus_ack) begin
                  rem_q   <= rem_next;
                  final_q <= predec_q ? cur_q : (cur_q + step);
                  if (rem_next != '0) begin
                     cur_q <= next_addr;
                  end else if (load_q) begin
                     cur_q   <= next_addr;
                     state_q <= ST_DUMMY;
                  end else begin
                     state_q   <= ST_IDLE;
                     done_q    <= 1'b1;
                     base_we_q <= wb_q;
                  end
               end
            end
            ST_DUMMY: begin
               if (bus_ack) begin
                  state_q   <= ST_IDLE;
                  done_q    <= 1'b1;
                  base_we_q <= wb_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/movem_seq_chk.sv
module movem_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_ack,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [IDX_W-1:0]  reg_idx,
   input logic              rf_we,
   input logic [DATA_W-1:0] rf_wdata,
   input logic              long_q,
   input logic              done,
   input logic              illegal,
   input logic              base_we
);
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(reg_idx));

   assert_we_in_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> bus_req);

   assert_rfwe_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> bus_req && !bus_we && bus_ack);

   assert_illegal_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done && !base_we && !bus_req);

   assert_wb_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |-> done);

   assert_word_sext_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we && !long_q |-> rf_wdata[DATA_W-1:16] == {(DATA_W-16){rf_wdata[15]}});

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req ##1 !done);
endmodule

bind movem_seq movem_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_ack  (bus_ack),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .reg_idx  (reg_idx),
   .rf_we    (rf_we),
   .rf_wdata (rf_wdata),
   .long_q   (long_q),
   .done     (done),
   .illegal  (illegal),
   .base_we  (base_we)
);

// File: tb/tb_movem_seq.sv
module tb_movem_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] list_mask = '0;
   logic [31:0] base_addr = '0;
   logic        to_mem = 1'b0;
   logic        long_sz = 1'b0;
   logic [2:0]  ea_mode = '0;
   logic [2:0]  ea_reg = '0;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        bus_req, bus_we, rf_we, done, illegal, base_we;
   logic [31:0] bus_addr, rf_wdata, final_addr;
   logic [3:0]  reg_idx;

   int total = 0;
   int fails = 0;

   always #4 clk = ~clk;

   movem_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .list_mask(list_mask),
      .base_addr(base_addr), .to_mem(to_mem), .long_sz(long_sz),
      .ea_mode(ea_mode), .ea_reg(ea_reg), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .reg_idx(reg_idx), .rf_we(rf_we),
      .rf_wdata(rf_wdata), .done(done), .illegal(illegal),
      .final_addr(final_addr), .base_we(base_we)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit legal_mode(input bit st, input logic [2:0] m, input logic [2:0] r);
      if (st) return (m == 3'b010 || m == 3'b100 || m == 3'b101 || m == 3'b110 ||
                      (m == 3'b111 && r <= 3'd1));
      return (m == 3'b010 || m == 3'b011 || m == 3'b101 || m == 3'b110 ||
              (m == 3'b111 && r <= 3'd3));
   endfunction

   task automatic run_op(input logic [15:0] m, input logic [31:0] base, input bit st,
                         input bit lg, input logic [2:0] md, input logic [2:0] rg);
      bit          pre = (md == 3'b100);
      bit          wb  = (md == 3'b100) || (md == 3'b011);
      bit          ok  = legal_mode(st, md, rg);
      logic [31:0] stp = lg ? 32'd4 : 32'd2;
      logic [31:0] ea, fin, rd, expd;
      int          n = 0;
      @(negedge clk);
      list_mask = m; base_addr = base; to_mem = st; long_sz = lg;
      ea_mode = md; ea_reg = rg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (!ok || m == 16'h0) begin
         chk({31'b0, done}, 32'd1, ok ? "R11 done empty" : "R8 done illegal");
         chk({31'b0, illegal}, {31'b0, !ok}, "R8 illegal flag");
         chk({31'b0, bus_req}, 32'd0, "R8/R11 no request");
         if (ok) begin
            chk(final_addr, base, "R11 final addr");
            chk({31'b0, base_we}, {31'b0, wb}, "R11 base_we");
         end else begin
            chk({31'b0, base_we}, 32'd0, "R8 base_we");
         end
         @(negedge clk);
         chk({31'b0, done | illegal | bus_req}, 32'd0, "R12 pulse cleared");
         return;
      end
      fin = base;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            ea = pre ? base - (n + 1) * stp : base + n * stp;
            for (int w = 0; w <= n % 3; w++) begin
               chk({31'b0, bus_req}, 32'd1, "R3 request");
               chk(bus_addr, ea, "R4 address");
               chk({28'b0, reg_idx}, pre ? 32'(15 - i) : 32'(i), pre ? "R2 reverse idx" : "R1 idx");
               chk({31'b0, bus_we}, {31'b0, st}, "R4 write strobe");
               if (w < n % 3) @(negedge clk);
            end
            rd = 32'h8000_0000 ^ (32'(i) * 32'h0009_1A37) ^ ((n % 2 == 1) ? 32'h0000_8000 : 32'h0);
            bus_rdata = rd; bus_ack = 1'b1;
            #1;
            expd = lg ? rd : {{16{rd[15]}}, rd[15:0]};
            chk({31'b0, rf_we}, {31'b0, !st}, "R10 rf_we");
            if (!st) chk(rf_wdata, expd, "R10 load data");
            @(negedge clk);
            bus_ack = 1'b0;
            fin = pre ? ea : ea + stp;
            n++;
         end
      end
      if (!st) begin
         chk({31'b0, bus_req}, 32'd1, "R5 dummy request");
         chk(bus_addr, base + n * stp, "R5 dummy address");
         chk({31'b0, bus_we}, 32'd0, "R5 dummy is read");
         bus_ack = 1'b1;
         #1;
         chk({31'b0, rf_we}, 32'd0, "R5 dummy no rf write");
         @(negedge clk);
         bus_ack = 1'b0;
      end
      chk({31'b0, done}, 32'd1, "R12 done");
      chk({31'b0, bus_req}, 32'd0, "R12 request dropped");
      chk({31'b0, illegal}, 32'd0, "R6/R7 legal");
      chk(final_addr, fin, "R9 final addr");
      chk({31'b0, base_we}, {31'b0, wb}, "R9 base_we");
      @(negedge clk);
      chk({31'b0, done}, 32'd0, "R12 single pulse");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; total++;
      $display("FAIL R12 watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [15:0] pats [6];
      pats = '{16'h0000, 16'hFFFF, 16'h8001, 16'h00FF, 16'hFF00, 16'h5A3C};
      repeat (3) @(negedge clk);
      chk({29'b0, bus_req, done, illegal}, 32'd0, "R12 reset strobes");
      chk({31'b0, base_we}, 32'd0, "R12 reset base_we");
      rst_n = 1'b1;
      for (int sz = 0; sz < 2; sz++) begin
         for (int b = 0; b < 16; b++) begin
            run_op(16'(1 << b), 32'h0000_2000, 1'b0, sz[0], 3'b010, 3'd0);
            run_op(16'(1 << b), 32'h0000_3000, 1'b1, sz[0], 3'b100, 3'd0);
         end
         foreach (pats[p]) begin
            run_op(pats[p], 32'h0001_0000, 1'b0, sz[0], 3'b011, 3'd1);
            run_op(pats[p], 32'h0002_0000, 1'b1, sz[0], 3'b100, 3'd7);
            run_op(pats[p], 32'h0003_0000, 1'b1, sz[0], 3'b010, 3'd2);
            run_op(pats[p], 32'h0004_0000, 1'b0, sz[0], 3'b111, 3'd2);
         end
      end
      // R6: every load mode/register pair
      for (int md = 0; md < 8; md++)
         for (int rg = 0; rg < 8; rg++)
            run_op(16'h0101, 32'h0000_5000, 1'b0, 1'b1, 3'(md), 3'(rg));
      // R7: every store mode/register pair
      for (int md = 0; md < 8; md++)
         for (int rg = 0; rg < 8; rg++)
            run_op(16'h8080, 32'h0000_6000, 1'b1, 1'b0, 3'(md), 3'(rg));
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule